// File: doc/BRIEF.md
# Supply Fault Latch Controller

This block supervises a converter's output rails from comparator flags. Four main rails (3.3 V, +5 V, +12 V and -12 V) each supply an overvoltage flag and an undervoltage flag. One auxiliary rail supplies an overvoltage flag. Every flag must stay asserted for a qualification time before it counts. The 3.3 V and 5 V undervoltage flags use a long window. All other flags use a short window. A qualified main-rail fault raises `main_fault`, which stops the main converter. A qualified auxiliary overvoltage raises both `aux_fault` and `main_fault`.

The power-on request is debounced before the block uses it. While the debounced request is off, the main fault latch is held clear and main-rail flags cannot set it, so switching the request off and back on clears a main fault. In restart mode, a main fault caused only by undervoltage clears itself after a restart interval. A fault that involved overvoltage stays latched. The auxiliary latch ignores the power-on request and clears only through the logic-supply undervoltage flag. That flag is the reset of the whole block: it asserts asynchronously and releases synchronously.

All time constants are given in microseconds and converted to clock cycles through the `CLK_HZ` parameter. A bench can therefore run the same logic on scaled timings.

Top module: `supply_fault_ctrl`

## Requirements
- R1: While `vdd_uv` is high, and for the clock edges it takes the reset to release, both `main_fault` and `aux_fault` are driven low and every latch and timer is cleared, including a latched auxiliary fault.
- R2: Rail index encoding in `rail_ov` and `rail_uv` is bit 0 = 3.3 V, bit 1 = +5 V, bit 2 = +12 V, bit 3 = -12 V. A main overvoltage flag held high for OV_US worth of clock edges sets `main_fault` on the following edge. A pulse one edge shorter leaves `main_fault` low.
- R3: An undervoltage flag on bit 0 or bit 1 must be held for UV_LONG_US before it sets `main_fault`. Bits 2 and 3 need only UV_SHORT_US. Each uses the same one-edge latching delay as R2, and a shorter pulse has no effect.
- R4: When `ov5_dis` is high, overvoltage on bit 1 is ignored. When `ov12_dis` is high, overvoltage on bit 2 is ignored. The -12 V and 3.3 V overvoltage paths are unaffected by either select.
- R5: In latching mode (`restart_sel` = 0), a main fault stays high until the debounced power-on request goes low. While that request is low, `main_fault` equals `aux_fault`.
- R6: A change on `pwr_on_req` takes effect only after it has stayed at the new level for PON_US worth of clock edges. A shorter change is discarded.
- R7: In restart mode (`restart_sel` = 1), a main fault latched only by undervoltage clears RESTART_US after it was latched. A main fault that involved any overvoltage never clears automatically.
- R8: An auxiliary overvoltage held for OV_US latches `aux_fault` and forces `main_fault` high. Cycling the power-on request clears neither output; only R1 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_HZ |
| vdd_uv | input | 1 | Logic-supply undervoltage, active-high reset |
| pwr_on_req | input | 1 | Raw power-on request |
| restart_sel | input | 1 | 0 = latching mode, 1 = timed restart mode |
| ov5_dis | input | 1 | Disables +5 V overvoltage detection |
| ov12_dis | input | 1 | Disables +12 V overvoltage detection |
| rail_ov | input | 4 | Main rail overvoltage flags |
| rail_uv | input | 4 | Main rail undervoltage flags |
| aux_ov | input | 1 | Auxiliary rail overvoltage flag |
| main_fault | output | 1 | Main fault, stops the main converter |
| aux_fault | output | 1 | Auxiliary overvoltage fault |

## Verification
Each flag qualifier needs N edges of a continuously high flag, where N is the qualification time in cycles, and the fault latch then sets on edge N+1. The bench drives inputs just after a falling edge. It samples at the falling edge after edge N, expecting low, and after edge N+1, expecting high. The power-on debounce changes its internal level on edge PON, so a fault clear or set that depends on it appears one edge later, at PON+1. A restart clears the fault exactly RESTART edges after the latching edge. The bench probes one edge before and one edge after each of these points.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam int RAILS  = 4;
  localparam int R_3V3  = 0;
  localparam int R_5V   = 1;
  localparam int R_12P  = 2;
  localparam int R_12N  = 3;

  // microseconds to clock cycles (CLK_HZ is a whole number of MHz)
  function automatic int us_cycles(input int clk_hz, input int us);
    return (clk_hz / 1_000_000) * us;
  endfunction

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sfl_rst_sync.sv
module sfl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_rst,
  output logic rst_out
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or posedge async_rst) begin
    if (async_rst) sh <= '1;
    else           sh <= {sh[STAGES-2:0], 1'b0};
  end

  assign rst_out = sh[STAGES-1];
endmodule

// File: rtl/sfl_qual.sv
module sfl_qual #(
  parameter int CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  output logic valid
);
  localparam int W = sfl_pkg::cnt_w(CYC);
  localparam logic [W-1:0] LIM = W'(CYC);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !flag) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign valid = (cnt == LIM);
endmodule

// File: rtl/sfl_debounce.sv
module sfl_debounce #(
  parameter int CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int W = sfl_pkg::cnt_w(CYC);
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= 1'b0;
      cnt  <= '0;
    end else if (raw == filt) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      filt <= raw;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfl_fault_core.sv
module sfl_fault_core #(
  parameter int RESTART_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic pon_ok,
  input  logic bounce,
  input  logic ov_hit,
  input  logic uv_hit,
  input  logic aux_hit,
  output logic m_lat,
  output logic aux_lat
);
  localparam int W = sfl_pkg::cnt_w(RESTART_CYC);
  localparam logic [W-1:0] LAST = W'(RESTART_CYC - 1);

  logic         ov_cause;
  logic [W-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst) aux_lat <= 1'b0;
    else if (aux_hit) aux_lat <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !pon_ok) begin
      m_lat    <= 1'b0;
      ov_cause <= 1'b0;
      rcnt     <= '0;
    end else if (!m_lat) begin
      rcnt <= '0;
      if (ov_hit || uv_hit) begin
        m_lat    <= 1'b1;
        ov_cause <= ov_hit;
      end
    end else begin
      if (ov_hit) ov_cause <= 1'b1;
      if (bounce && !ov_cause && !ov_hit) begin
        if (rcnt == LAST) begin
          m_lat <= 1'b0;
          rcnt  <= '0;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end else begin
        rcnt <= '0;
      end
    end
  end
endmodule

// File: rtl/supply_fault_ctrl.sv
module supply_fault_ctrl #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int OV_US       = 6,
  parameter int UV_LONG_US  = 480,
  parameter int UV_SHORT_US = 6,
  parameter int PON_US      = 75_000,
  parameter int RESTART_US  = 1_000_000
) (
  input  logic       clk,
  input  logic       vdd_uv,
  input  logic       pwr_on_req,
  input  logic       restart_sel,
  input  logic       ov5_dis,
  input  logic       ov12_dis,
  input  logic [3:0] rail_ov,
  input  logic [3:0] rail_uv,
  input  logic       aux_ov,
  output logic       main_fault,
  output logic       aux_fault
);
  import sfl_pkg::*;

  localparam int OV_CYC   = us_cycles(CLK_HZ, OV_US);
  localparam int UVL_CYC  = us_cycles(CLK_HZ, UV_LONG_US);
  localparam int UVS_CYC  = us_cycles(CLK_HZ, UV_SHORT_US);
  localparam int PON_CYC  = us_cycles(CLK_HZ, PON_US);
  localparam int RST_CYC  = us_cycles(CLK_HZ, RESTART_US);

  logic             rst_int;
  logic             pon_ok;
  logic [RAILS-1:0] ov_en;
  logic [RAILS-1:0] ov_q;
  logic [RAILS-1:0] uv_q;
  logic             aux_q;
  logic             m_lat;
  logic             aux_lat;

  sfl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .async_rst(vdd_uv), .rst_out(rst_int)
  );

  sfl_debounce #(.CYC(PON_CYC)) u_pon (
    .clk(clk), .rst(rst_int), .raw(pwr_on_req), .filt(pon_ok)
  );

  always_comb begin
    ov_en        = '1;
    ov_en[R_5V]  = ~ov5_dis;
    ov_en[R_12P] = ~ov12_dis;
  end

  for (genvar i = 0; i < RAILS; i++) begin : g_rail
    localparam int UVC = (i == R_3V3 || i == R_5V) ? UVL_CYC : UVS_CYC;

    sfl_qual #(.CYC(OV_CYC)) u_ovq (
      .clk(clk), .rst(rst_int), .flag(rail_ov[i] & ov_en[i]), .valid(ov_q[i])
    );
    sfl_qual #(.CYC(UVC)) u_uvq (
      .clk(clk), .rst(rst_int), .flag(rail_uv[i]), .valid(uv_q[i])
    );
  end

  sfl_qual #(.CYC(OV_CYC)) u_auxq (
    .clk(clk), .rst(rst_int), .flag(aux_ov), .valid(aux_q)
  );

  sfl_fault_core #(.RESTART_CYC(RST_CYC)) u_core (
    .clk(clk), .rst(rst_int), .pon_ok(pon_ok), .bounce(restart_sel),
    .ov_hit(|ov_q), .uv_hit(|uv_q), .aux_hit(aux_q),
    .m_lat(m_lat), .aux_lat(aux_lat)
  );

  assign main_fault = m_lat | aux_lat;
  assign aux_fault  = aux_lat;
endmodule

// File: rtl/sfl_checker.sv
module sfl_checker (
  input logic clk,
  input logic rst,
  input logic pwr_on_req,
  input logic pon_ok,
  input logic restart_sel,
  input logic main_fault,
  input logic aux_fault
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (1'b0)
    $past(rst) |-> (!main_fault && !aux_fault));

  // R8
  aux_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    aux_fault |=> aux_fault);

  // R8
  aux_forces_main_chk: assert property (@(posedge clk) disable iff (rst)
    aux_fault |-> main_fault);

  // R5
  pon_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !pon_ok |=> (main_fault == aux_fault));

  // R6
  pon_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pon_ok) |-> (pon_ok == $past(pwr_on_req)));

  // R7
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(main_fault) |-> ($past(!pon_ok) || $past(restart_sel)));
endmodule

bind supply_fault_ctrl sfl_checker u_chk (
  .clk(clk), .rst(rst_int), .pwr_on_req(pwr_on_req), .pon_ok(pon_ok),
  .restart_sel(restart_sel), .main_fault(main_fault), .aux_fault(aux_fault)
);

// File: tb/supply_fault_ctrl_bench.sv
module supply_fault_ctrl_bench;
  localparam int OVN  = 6;
  localparam int UVL  = 480;
  localparam int UVS  = 6;
  localparam int PONN = 20;
  localparam int RSTN = 200;

  logic       clk = 1'b0;
  logic       vdd_uv = 1'b1;
  logic       pwr_on_req = 1'b0;
  logic       restart_sel = 1'b0;
  logic       ov5_dis = 1'b0;
  logic       ov12_dis = 1'b0;
  logic [3:0] rail_ov = '0;
  logic [3:0] rail_uv = '0;
  logic       aux_ov = 1'b0;
  logic       main_fault;
  logic       aux_fault;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  supply_fault_ctrl #(
    .CLK_HZ(1_000_000), .OV_US(OVN), .UV_LONG_US(UVL), .UV_SHORT_US(UVS),
    .PON_US(PONN), .RESTART_US(RSTN)
  ) u_supply_fault_ctrl (
    .clk(clk), .vdd_uv(vdd_uv), .pwr_on_req(pwr_on_req),
    .restart_sel(restart_sel), .ov5_dis(ov5_dis), .ov12_dis(ov12_dis),
    .rail_ov(rail_ov), .rail_uv(rail_uv), .aux_ov(aux_ov),
    .main_fault(main_fault), .aux_fault(aux_fault)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic power_up();
    pwr_on_req = 1'b1;
    step(PONN + 2);
  endtask

  task automatic power_down();
    pwr_on_req = 1'b0;
    step(PONN + 2);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 reset main", main_fault, 1'b0);
    chk("R1 reset aux", aux_fault, 1'b0);
    vdd_uv = 1'b0;
    step(3);

    // R6: short request pulse is discarded while OV is held
    rail_ov[0] = 1'b1;
    pwr_on_req = 1'b1;
    step(PONN - 1);
    pwr_on_req = 1'b0;
    step(30);
    chk("R6 short request ignored", main_fault, 1'b0);
    // R6: full request, latch appears on edge PONN+1
    pwr_on_req = 1'b1;
    step(PONN);
    chk("R6 before debounce", main_fault, 1'b0);
    step(1);
    chk("R6 after debounce", main_fault, 1'b1);
    rail_ov[0] = 1'b0;
    // R5: clear appears on edge PONN+1 after request drops
    pwr_on_req = 1'b0;
    step(PONN);
    chk("R5 held until request off", main_fault, 1'b1);
    step(1);
    chk("R5 cleared by request off", main_fault, 1'b0);
    // R5: flags ignored while request off
    rail_uv[2] = 1'b1;
    step(20);
    chk("R5 UV ignored while off", main_fault, 1'b0);
    rail_uv[2] = 1'b0;
    step(2);
    power_up();

    // R2 sweep over every rail
    for (int r = 0; r < 4; r++) begin
      rail_ov[r] = 1'b1;
      step(OVN - 1);
      rail_ov[r] = 1'b0;
      step(3);
      chk("R2 short OV ignored", main_fault, 1'b0);
      rail_ov[r] = 1'b1;
      step(OVN);
      chk("R2 OV not yet", main_fault, 1'b0);
      step(1);
      chk("R2 OV latched", main_fault, 1'b1);
      rail_ov[r] = 1'b0;
      step(RSTN + 5);
      chk("R5 OV stays latched", main_fault, 1'b1);
      power_down();
      chk("R5 OV cleared by cycling", main_fault, 1'b0);
      power_up();
    end

    // R3 sweep over every rail
    for (int r = 0; r < 4; r++) begin
      automatic int n = (r < 2) ? UVL : UVS;
      rail_uv[r] = 1'b1;
      step(n - 1);
      rail_uv[r] = 1'b0;
      step(3);
      chk("R3 short UV ignored", main_fault, 1'b0);
      rail_uv[r] = 1'b1;
      step(n);
      chk("R3 UV not yet", main_fault, 1'b0);
      step(1);
      chk("R3 UV latched", main_fault, 1'b1);
      rail_uv[r] = 1'b0;
      power_down();
      chk("R5 UV cleared by cycling", main_fault, 1'b0);
      power_up();
    end

    // R4 disables
    ov5_dis = 1'b1;
    ov12_dis = 1'b1;
    rail_ov[1] = 1'b1;
    step(40);
    chk("R4 +5V OV disabled", main_fault, 1'b0);
    rail_ov[1] = 1'b0;
    rail_ov[2] = 1'b1;
    step(40);
    chk("R4 +12V OV disabled", main_fault, 1'b0);
    rail_ov[2] = 1'b0;
    rail_ov[3] = 1'b1;
    step(OVN + 1);
    chk("R4 -12V OV still active", main_fault, 1'b1);
    rail_ov[3] = 1'b0;
    ov5_dis = 1'b0;
    ov12_dis = 1'b0;
    power_down();
    power_up();

    // R7 restart after UV-only fault
    restart_sel = 1'b1;
    rail_uv[2] = 1'b1;
    step(UVS + 1);
    chk("R7 UV latched", main_fault, 1'b1);
    rail_uv[2] = 1'b0;
    step(RSTN - 1);
    chk("R7 before restart", main_fault, 1'b1);
    step(1);
    chk("R7 restarted", main_fault, 1'b0);
    // R7 OV fault never restarts
    rail_ov[0] = 1'b1;
    step(OVN + 1);
    chk("R7 OV latched", main_fault, 1'b1);
    rail_ov[0] = 1'b0;
    step(RSTN + 20);
    chk("R7 OV no restart", main_fault, 1'b1);
    restart_sel = 1'b0;
    power_down();

    // R8 auxiliary overvoltage
    power_up();
    aux_ov = 1'b1;
    step(OVN - 1);
    aux_ov = 1'b0;
    step(3);
    chk("R8 short aux ignored", aux_fault, 1'b0);
    aux_ov = 1'b1;
    step(OVN);
    chk("R8 aux not yet", aux_fault, 1'b0);
    step(1);
    chk("R8 aux latched", aux_fault, 1'b1);
    chk("R8 main forced", main_fault, 1'b1);
    aux_ov = 1'b0;
    power_down();
    chk("R8 aux survives cycling", aux_fault, 1'b1);
    chk("R8 main survives cycling", main_fault, 1'b1);
    vdd_uv = 1'b1;
    step(1);
    chk("R1 reset clears aux", aux_fault, 1'b0);
    chk("R1 reset clears main", main_fault, 1'b0);
    vdd_uv = 1'b0;
    step(3);
    chk("R1 stays clear after release", main_fault, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule